// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block gives a host a two-window path into the configuration space of devices behind it. One window holds a 32-bit address latch. The latch chooses a bus, a device/function pair and a register offset, and its top bit enables the second window. The second window is a data port. Each access to it becomes one configuration read or write request on a downstream port, or the block answers it at once with all ones when no request may be made.

The downstream side has two parts. A combinational lookup port carries the latched bus and device/function numbers out and brings back three flags: a device answers there, function 0 of that device exists, and the device was hot-added. A request port carries the effective offset, a 4-bit byte-enable mask and lane-shifted write data, and waits for an acknowledge with read data. Reads return data right-aligned to the host access. The host bus uses a valid/ready handshake. The host holds `h_valid` and its qualifiers until it sees `h_ready`, which is a one-cycle pulse.

Top module: `cfgx_bridge`

## Requirements
- R1: A write to the address window (`h_win`=0) loads the latch only when `h_addr`=0 and `h_len`=4. Any other write to that window leaves the latch unchanged.
- R2: A read of the address window returns the latch value as it stands.
- R3: Latch bits 23:16 give the bus number and bits 15:8 give the device/function number, on both the lookup and the request outputs. Bits 7:0 give the base register offset.
- R4: When latch bit 31 is 0, a data-window read returns 0xFFFFFFFF and a data-window write makes no downstream request.
- R5: The effective offset is latch[7:0] OR `h_addr`. Byte `k` of the request is enabled when `k` lies in [offset[1:0], offset[1:0]+n-1] and k<4, where n is the clipped length. Read data is `rq_rdata` shifted right by 8×offset[1:0] and masked to n bytes.
- R6: With `lk_present`=0, a read returns 0xFFFFFFFF and a write makes no request.
- R7: An effective offset at or above `CFG_LIMIT` (at most 256) gives an all-ones read and no request for a write. Below the limit, n = min(`h_len`, `CFG_LIMIT` − offset).
- R8: With `lk_hot_added`=1 and `lk_fn0_present`=0, a read returns 0xFFFFFFFF and a write makes no request. With `lk_fn0_present`=1, or with a device that was not hot-added, the access is forwarded.
- R9: A forwarded write drives `rq_write`=1, `rq_wdata` = `h_wdata` shifted left by 8×offset[1:0], and the R5 byte enables.
- R10: Address-window and all-ones responses raise `h_ready` one cycle after acceptance. A forwarded access raises `rq_valid` the cycle after acceptance and holds it, with stable fields, until `rq_ack`. `h_ready` follows one cycle after the acknowledge and lasts one cycle.
- R11: Synchronous reset clears the latch to zero, which disables the data window, and leaves `h_ready` and `rq_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| h_valid | input | 1 | Host access request |
| h_write | input | 1 | 1 = write, 0 = read |
| h_win | input | 1 | 0 = address window, 1 = data window |
| h_addr | input | 2 | Byte address within the window |
| h_len | input | 3 | Access length in bytes: 1, 2 or 4 |
| h_wdata | input | 32 | Host write data, right-aligned |
| h_ready | output | 1 | One-cycle completion pulse |
| h_rdata | output | 32 | Read data, valid with h_ready |
| lk_bus | output | 8 | Bus number under lookup |
| lk_devfn | output | 8 | Device/function under lookup |
| lk_present | input | 1 | A device answers at the lookup target |
| lk_fn0_present | input | 1 | Function 0 of that device exists |
| lk_hot_added | input | 1 | The target was hot-added |
| rq_valid | output | 1 | Configuration request pending |
| rq_write | output | 1 | Request is a write |
| rq_bus | output | 8 | Request bus number |
| rq_devfn | output | 8 | Request device/function |
| rq_off | output | 8 | Effective register offset |
| rq_be | output | 4 | Byte enables |
| rq_wdata | output | 32 | Lane-aligned write data |
| rq_ack | input | 1 | Request accepted; rq_rdata valid |
| rq_rdata | input | 32 | Read data from target |

## Verification
Address-window accesses and all-ones responses are due on the first falling edge after the accepting clock edge. Forwarded accesses complete on the second falling edge when the acknowledge comes back at once. With an acknowledge delayed by `w` cycles they complete on falling edge `w+2`. The bench drives inputs and samples outputs only on falling edges, and it counts those edges from the accepting edge to `h_ready`. Each access is checked against the latency due for its path. Requests are captured on the falling edge where `rq_valid` and `rq_ack` are both high, so a dropped write shows as an unchanged request count.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam int unsigned LAT_W  = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RESP = 2'd2
  } cfgx_state_e;

  // Bytes actually moved: host length capped at one word, then at what is
  // left below the configuration limit.
  function automatic logic [2:0] clip_len(input logic [2:0] len,
                                          input logic [9:0] remain);
    logic [2:0] n;
    n = (len > 3'd4) ? 3'd4 : len;
    if (remain < {7'd0, n}) n = remain[2:0];
    return n;
  endfunction

  // Byte-enable mask starting at lane, n bytes wide, truncated to one word.
  function automatic logic [LANES-1:0] byte_en(input logic [1:0] lane,
                                               input logic [2:0] n);
    logic [7:0] m;
    m = (8'd1 << n) - 8'd1;
    m = m << lane;
    return m[LANES-1:0];
  endfunction

  // Mask keeping the low n bytes of a right-aligned word.
  function automatic logic [DATA_W-1:0] low_bytes(input logic [2:0] n);
    logic [DATA_W-1:0] m;
    case (n)
      3'd1:    m = 32'h0000_00FF;
      3'd2:    m = 32'h0000_FFFF;
      3'd3:    m = 32'h00FF_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cfgx_addr_latch.sv
module cfgx_addr_latch
  import cfgx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_fire,
  input  logic [1:0]       h_addr,
  input  logic [2:0]       h_len,
  input  logic [LAT_W-1:0] h_wdata,
  output logic [LAT_W-1:0] lat_q,
  output logic             lat_upd
);

  // Only a full-word write at window byte 0 reaches the latch.
  assign lat_upd = wr_fire && (h_addr == 2'd0) && (h_len == 3'd4);

  always_ff @(posedge clk) begin
    if (rst)          lat_q <= '0;
    else if (lat_upd) lat_q <= h_wdata;
  end

endmodule

// File: rtl/cfgx_gate.sv
module cfgx_gate
  import cfgx_pkg::*;
#(
  parameter int unsigned CFG_LIMIT = 256
)(
  input  logic             en_bit,
  input  logic [7:0]       base_off,
  input  logic [1:0]       h_addr,
  input  logic [2:0]       h_len,
  input  logic             lk_present,
  input  logic             lk_fn0_present,
  input  logic             lk_hot_added,
  output logic [7:0]       eff_off,
  output logic [2:0]       nbytes,
  output logic [LANES-1:0] be,
  output logic             allow
);

  localparam logic [9:0] LIM_V = CFG_LIMIT[9:0];

  logic       in_range;
  logic       visible;
  logic [9:0] remain;

  assign eff_off  = base_off | {6'd0, h_addr};
  assign in_range = ({2'b00, eff_off} < LIM_V);
  assign visible  = lk_present && !(lk_hot_added && !lk_fn0_present);
  assign remain   = LIM_V - {2'b00, eff_off};
  assign nbytes   = clip_len(h_len, remain);
  assign be       = byte_en(eff_off[1:0], nbytes);
  assign allow    = en_bit && in_range && visible;

endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
  import cfgx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              h_valid,
  input  logic              h_write,
  input  logic              h_win,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic [LAT_W-1:0]  lat,
  input  logic              allow,
  input  logic [7:0]        eff_off,
  input  logic [2:0]        nbytes,
  input  logic [LANES-1:0]  be,
  input  logic              rq_ack,
  input  logic [DATA_W-1:0] rq_rdata,
  output logic              h_ready,
  output logic [DATA_W-1:0] h_rdata,
  output logic              rq_valid,
  output logic              rq_write,
  output logic [7:0]        rq_bus,
  output logic [7:0]        rq_devfn,
  output logic [7:0]        rq_off,
  output logic [LANES-1:0]  rq_be,
  output logic [DATA_W-1:0] rq_wdata,
  output logic              acc_evt,
  output logic              fwd_evt,
  output logic              synth_evt
);

  cfgx_state_e       state_q;
  logic [DATA_W-1:0] rsp_q;
  logic [1:0]        lane_q;
  logic [2:0]        n_q;

  assign acc_evt   = (state_q == ST_IDLE) && h_valid;
  assign fwd_evt   = acc_evt && h_win && allow;
  assign synth_evt = acc_evt && h_win && !allow;
  assign h_ready   = (state_q == ST_RESP);
  assign h_rdata   = rsp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      rsp_q    <= '0;
      lane_q   <= '0;
      n_q      <= '0;
      rq_valid <= 1'b0;
      rq_write <= 1'b0;
      rq_bus   <= '0;
      rq_devfn <= '0;
      rq_off   <= '0;
      rq_be    <= '0;
      rq_wdata <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (acc_evt && !h_win) begin
            rsp_q   <= lat;
            state_q <= ST_RESP;
          end else if (synth_evt) begin
            rsp_q   <= '1;
            state_q <= ST_RESP;
          end else if (fwd_evt) begin
            rq_valid <= 1'b1;
            rq_write <= h_write;
            rq_bus   <= lat[23:16];
            rq_devfn <= lat[15:8];
            rq_off   <= eff_off;
            rq_be    <= be;
            rq_wdata <= h_wdata << {eff_off[1:0], 3'b000};
            lane_q   <= eff_off[1:0];
            n_q      <= nbytes;
            state_q  <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (rq_ack) begin
            rq_valid <= 1'b0;
            rsp_q    <= (rq_rdata >> {lane_q, 3'b000}) & low_bytes(n_q);
            state_q  <= ST_RESP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfgx_bridge.sv
module cfgx_bridge
  import cfgx_pkg::*;
#(
  parameter int unsigned CFG_LIMIT = 256
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        h_valid,
  input  logic        h_write,
  input  logic        h_win,
  input  logic [1:0]  h_addr,
  input  logic [2:0]  h_len,
  input  logic [31:0] h_wdata,
  output logic        h_ready,
  output logic [31:0] h_rdata,
  output logic [7:0]  lk_bus,
  output logic [7:0]  lk_devfn,
  input  logic        lk_present,
  input  logic        lk_fn0_present,
  input  logic        lk_hot_added,
  output logic        rq_valid,
  output logic        rq_write,
  output logic [7:0]  rq_bus,
  output logic [7:0]  rq_devfn,
  output logic [7:0]  rq_off,
  output logic [3:0]  rq_be,
  output logic [31:0] rq_wdata,
  input  logic        rq_ack,
  input  logic [31:0] rq_rdata
);

  logic [LAT_W-1:0] lat_q;
  logic             lat_upd;
  logic             acc_evt;
  logic             fwd_evt;
  logic             synth_evt;
  logic [7:0]       eff_off;
  logic [2:0]       nbytes;
  logic [LANES-1:0] be;
  logic             allow;

  assign lk_bus   = lat_q[23:16];
  assign lk_devfn = lat_q[15:8];

  cfgx_addr_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .wr_fire (acc_evt && !h_win && h_write),
    .h_addr  (h_addr),
    .h_len   (h_len),
    .h_wdata (h_wdata),
    .lat_q   (lat_q),
    .lat_upd (lat_upd)
  );

  cfgx_gate #(.CFG_LIMIT(CFG_LIMIT)) u_gate (
    .en_bit         (lat_q[31]),
    .base_off       (lat_q[7:0]),
    .h_addr         (h_addr),
    .h_len          (h_len),
    .lk_present     (lk_present),
    .lk_fn0_present (lk_fn0_present),
    .lk_hot_added   (lk_hot_added),
    .eff_off        (eff_off),
    .nbytes         (nbytes),
    .be             (be),
    .allow          (allow)
  );

  cfgx_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .h_valid   (h_valid),
    .h_write   (h_write),
    .h_win     (h_win),
    .h_wdata   (h_wdata),
    .lat       (lat_q),
    .allow     (allow),
    .eff_off   (eff_off),
    .nbytes    (nbytes),
    .be        (be),
    .rq_ack    (rq_ack),
    .rq_rdata  (rq_rdata),
    .h_ready   (h_ready),
    .h_rdata   (h_rdata),
    .rq_valid  (rq_valid),
    .rq_write  (rq_write),
    .rq_bus    (rq_bus),
    .rq_devfn  (rq_devfn),
    .rq_off    (rq_off),
    .rq_be     (rq_be),
    .rq_wdata  (rq_wdata),
    .acc_evt   (acc_evt),
    .fwd_evt   (fwd_evt),
    .synth_evt (synth_evt)
  );

endmodule

// File: rtl/cfgx_bridge_chk.sv
module cfgx_bridge_chk #(
  parameter int unsigned CFG_LIMIT = 256
)(
  input logic        clk,
  input logic        rst,
  input logic        h_valid,
  input logic        h_write,
  input logic        h_win,
  input logic [1:0]  h_addr,
  input logic [2:0]  h_len,
  input logic        h_ready,
  input logic [31:0] lat_q,
  input logic        lk_present,
  input logic        lk_fn0_present,
  input logic        lk_hot_added,
  input logic        rq_valid,
  input logic        rq_ack,
  input logic [7:0]  rq_bus,
  input logic [7:0]  rq_devfn,
  input logic [7:0]  rq_off,
  input logic [3:0]  rq_be,
  input logic [31:0] rq_wdata
);

  localparam logic [9:0] LIM_V = CFG_LIMIT[9:0];

  a_r1_latch_write_only: assert property (@(posedge clk) disable iff (rst)
    !$stable(lat_q) |-> $past(h_valid && h_write && !h_win && h_addr == 2'd0 && h_len == 3'd4));

  a_r3_fields_from_latch: assert property (@(posedge clk) disable iff (rst)
    $rose(rq_valid) |-> (rq_bus == $past(lat_q[23:16])) && (rq_devfn == $past(lat_q[15:8])));

  a_r4_enabled_only: assert property (@(posedge clk) disable iff (rst)
    rq_valid |-> lat_q[31]);

  a_r5_first_lane_enabled: assert property (@(posedge clk) disable iff (rst)
    rq_valid |-> rq_be[rq_off[1:0]]);

  a_r6_present_only: assert property (@(posedge clk) disable iff (rst)
    rq_valid |-> lk_present);

  a_r7_below_limit: assert property (@(posedge clk) disable iff (rst)
    rq_valid |-> ({2'b00, rq_off} < LIM_V));

  a_r8_not_hidden: assert property (@(posedge clk) disable iff (rst)
    rq_valid |-> !(lk_hot_added && !lk_fn0_present));

  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    rq_valid && !rq_ack |=> rq_valid && $stable(rq_off) && $stable(rq_be) && $stable(rq_wdata));

  a_r10_ack_then_ready: assert property (@(posedge clk) disable iff (rst)
    rq_valid && rq_ack |=> h_ready && !rq_valid);

  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    h_ready |=> !h_ready);

endmodule

bind cfgx_bridge cfgx_bridge_chk #(.CFG_LIMIT(CFG_LIMIT)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .h_valid        (h_valid),
  .h_write        (h_write),
  .h_win          (h_win),
  .h_addr         (h_addr),
  .h_len          (h_len),
  .h_ready        (h_ready),
  .lat_q          (lat_q),
  .lk_present     (lk_present),
  .lk_fn0_present (lk_fn0_present),
  .lk_hot_added   (lk_hot_added),
  .rq_valid       (rq_valid),
  .rq_ack         (rq_ack),
  .rq_bus         (rq_bus),
  .rq_devfn       (rq_devfn),
  .rq_off         (rq_off),
  .rq_be          (rq_be),
  .rq_wdata       (rq_wdata)
);

// File: tb/cfgx_bridge_bench.sv
module cfgx_bridge_bench;

  localparam int unsigned LIMIT = 192;
  localparam logic [31:0] PAT   = 32'hA1B2_C3D4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_valid = 1'b0, h_write = 1'b0, h_win = 1'b0;
  logic [1:0]  h_addr = '0;
  logic [2:0]  h_len = '0;
  logic [31:0] h_wdata = '0;
  logic        h_ready;
  logic [31:0] h_rdata;
  logic [7:0]  lk_bus, lk_devfn;
  logic        lk_present = 1'b1, lk_fn0_present = 1'b1, lk_hot_added = 1'b0;
  logic        rq_valid, rq_write, rq_ack;
  logic [7:0]  rq_bus, rq_devfn, rq_off;
  logic [3:0]  rq_be;
  logic [31:0] rq_wdata;

  int ack_wait = 0;
  int wait_cnt = 0;
  int n_req = 0, n_wr = 0;
  logic [7:0]  c_bus, c_devfn, c_off;
  logic [3:0]  c_be;
  logic [31:0] c_wdata;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  cfgx_bridge #(.CFG_LIMIT(LIMIT)) u_cfgx_bridge (
    .clk(clk), .rst(rst), .h_valid(h_valid), .h_write(h_write), .h_win(h_win),
    .h_addr(h_addr), .h_len(h_len), .h_wdata(h_wdata), .h_ready(h_ready),
    .h_rdata(h_rdata), .lk_bus(lk_bus), .lk_devfn(lk_devfn),
    .lk_present(lk_present), .lk_fn0_present(lk_fn0_present),
    .lk_hot_added(lk_hot_added), .rq_valid(rq_valid), .rq_write(rq_write),
    .rq_bus(rq_bus), .rq_devfn(rq_devfn), .rq_off(rq_off), .rq_be(rq_be),
    .rq_wdata(rq_wdata), .rq_ack(rq_ack), .rq_rdata(PAT)
  );

  // Target model: acknowledges after ack_wait cycles of rq_valid.
  always @(posedge clk) wait_cnt <= rq_valid ? wait_cnt + 1 : 0;
  assign rq_ack = rq_valid && (wait_cnt >= ack_wait);

  always @(negedge clk) begin
    if (!rst && rq_valid && rq_ack) begin
      n_req++;
      if (rq_write) n_wr++;
      c_bus = rq_bus; c_devfn = rq_devfn; c_off = rq_off;
      c_be = rq_be; c_wdata = rq_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host(input logic win, input logic we, input logic [1:0] a,
                      input logic [2:0] len, input logic [31:0] wd,
                      output logic [31:0] rd, output int cyc);
    @(negedge clk);
    h_valid = 1'b1; h_win = win; h_write = we; h_addr = a; h_len = len; h_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!h_ready && cyc < 50);
    rd = h_rdata;
    h_valid = 1'b0;
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] lat;
    logic [1:0]  a;
    logic [2:0]  len;
    logic        pres;
    logic        fn0;
    logic        hot;
    logic        fwd;
    logic [3:0]  be;
    logic [31:0] exp;
  } vec_t;

  // Reads through the data window; tags name R5, R7, R4, R6, R8.
  localparam vec_t VEC [13] = '{
    '{4'd5, 32'h8000_0010, 2'd0, 3'd4, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 32'hA1B2_C3D4},
    '{4'd5, 32'h8000_0010, 2'd1, 3'd1, 1'b1, 1'b1, 1'b0, 1'b1, 4'h2, 32'h0000_00C3},
    '{4'd5, 32'h8000_0010, 2'd2, 3'd2, 1'b1, 1'b1, 1'b0, 1'b1, 4'hC, 32'h0000_A1B2},
    '{4'd5, 32'h8000_0012, 2'd1, 3'd1, 1'b1, 1'b1, 1'b0, 1'b1, 4'h8, 32'h0000_00A1},
    '{4'd5, 32'h8000_0001, 2'd0, 3'd4, 1'b1, 1'b1, 1'b0, 1'b1, 4'hE, 32'h00A1_B2C3},
    '{4'd7, 32'h8000_00BE, 2'd0, 3'd4, 1'b1, 1'b1, 1'b0, 1'b1, 4'hC, 32'h0000_A1B2},
    '{4'd7, 32'h8000_00BF, 2'd0, 3'd4, 1'b1, 1'b1, 1'b0, 1'b1, 4'h8, 32'h0000_00A1},
    '{4'd7, 32'h8000_00C0, 2'd0, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 32'hFFFF_FFFF},
    '{4'd4, 32'h0000_0010, 2'd0, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 32'hFFFF_FFFF},
    '{4'd6, 32'h8000_0010, 2'd0, 3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 32'hFFFF_FFFF},
    '{4'd8, 32'h8000_0010, 2'd0, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 32'hFFFF_FFFF},
    '{4'd8, 32'h8000_0010, 2'd0, 3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 32'hA1B2_C3D4},
    '{4'd8, 32'h8000_0010, 2'd0, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 32'hA1B2_C3D4}
  };

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  initial begin
    logic [31:0] rd;
    int cyc, n0, w0;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 h_ready in reset", {31'd0, h_ready}, 32'd0);
    chk("R11 rq_valid in reset", {31'd0, rq_valid}, 32'd0);
    rst = 1'b0;
    host(1'b0, 1'b0, 2'd0, 3'd4, 32'd0, rd, cyc);
    chk("R11 latch after reset", rd, 32'd0);
    chk("R10 address read latency", cyc, 1);
    n0 = n_req;
    host(1'b1, 1'b0, 2'd0, 3'd4, 32'd0, rd, cyc);
    chk("R11 data window disabled after reset", rd, 32'hFFFF_FFFF);
    chk("R11 no request after reset", n_req - n0, 0);

    // R1 / R2: latch write qualification and read-back
    host(1'b0, 1'b1, 2'd0, 3'd4, 32'h8012_3456, rd, cyc);
    host(1'b0, 1'b0, 2'd0, 3'd4, 32'd0, rd, cyc);
    chk("R2 latch read-back", rd, 32'h8012_3456);
    host(1'b0, 1'b1, 2'd0, 3'd2, 32'h0000_0000, rd, cyc);
    host(1'b0, 1'b0, 2'd0, 3'd4, 32'd0, rd, cyc);
    chk("R1 short write ignored", rd, 32'h8012_3456);
    host(1'b0, 1'b1, 2'd1, 3'd4, 32'h0000_0000, rd, cyc);
    host(1'b0, 1'b0, 2'd0, 3'd4, 32'd0, rd, cyc);
    chk("R1 nonzero offset write ignored", rd, 32'h8012_3456);

    // R3: field decoding
    chk("R3 lookup bus", {24'd0, lk_bus}, 32'h12);
    chk("R3 lookup devfn", {24'd0, lk_devfn}, 32'h34);
    host(1'b1, 1'b0, 2'd0, 3'd4, 32'd0, rd, cyc);
    chk("R3 request bus", {24'd0, c_bus}, 32'h12);
    chk("R3 request devfn", {24'd0, c_devfn}, 32'h34);
    chk("R3 request offset", {24'd0, c_off}, 32'h56);

    // Vector table of data-window reads
    for (int i = 0; i < 13; i++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VEC[i].req, i);
      lk_present = VEC[i].pres; lk_fn0_present = VEC[i].fn0; lk_hot_added = VEC[i].hot;
      host(1'b0, 1'b1, 2'd0, 3'd4, VEC[i].lat, rd, cyc);
      n0 = n_req;
      host(1'b1, 1'b0, VEC[i].a, VEC[i].len, 32'd0, rd, cyc);
      chk({tg, " rdata"}, rd, VEC[i].exp);
      chk({tg, " forwarded"}, n_req - n0, {31'd0, VEC[i].fwd});
      chk({tg, " R10 latency"}, cyc, VEC[i].fwd ? 2 : 1);
      if (VEC[i].fwd) chk({tg, " byte enables"}, {28'd0, c_be}, {28'd0, VEC[i].be});
    end

    // R9: forwarded write with lane shift
    lk_present = 1'b1; lk_fn0_present = 1'b1; lk_hot_added = 1'b0;
    host(1'b0, 1'b1, 2'd0, 3'd4, 32'h8000_0010, rd, cyc);
    w0 = n_wr;
    host(1'b1, 1'b1, 2'd2, 3'd2, 32'h0000_BEEF, rd, cyc);
    chk("R9 write forwarded", n_wr - w0, 1);
    chk("R9 write data lanes", c_wdata, 32'hBEEF_0000);
    chk("R9 write byte enables", {28'd0, c_be}, 32'hC);
    chk("R9 write offset", {24'd0, c_off}, 32'h12);

    // Dropped writes: R6 absent, R8 hidden, R7 out of range, R4 disabled
    w0 = n_wr;
    lk_present = 1'b0;
    host(1'b1, 1'b1, 2'd0, 3'd4, 32'h1111_1111, rd, cyc);
    chk("R6 write to absent dropped", n_wr - w0, 0);
    lk_present = 1'b1; lk_fn0_present = 1'b0; lk_hot_added = 1'b1;
    host(1'b1, 1'b1, 2'd0, 3'd4, 32'h2222_2222, rd, cyc);
    chk("R8 write to hidden dropped", n_wr - w0, 0);
    lk_fn0_present = 1'b1; lk_hot_added = 1'b0;
    host(1'b0, 1'b1, 2'd0, 3'd4, 32'h8000_00C4, rd, cyc);
    host(1'b1, 1'b1, 2'd0, 3'd4, 32'h3333_3333, rd, cyc);
    chk("R7 write beyond limit dropped", n_wr - w0, 0);
    host(1'b0, 1'b1, 2'd0, 3'd4, 32'h0000_0010, rd, cyc);
    host(1'b1, 1'b1, 2'd0, 3'd4, 32'h4444_4444, rd, cyc);
    chk("R4 write while disabled dropped", n_wr - w0, 0);
    chk("R10 dropped write latency", cyc, 1);

    // R10: delayed acknowledge
    host(1'b0, 1'b1, 2'd0, 3'd4, 32'h8000_0020, rd, cyc);
    ack_wait = 3;
    host(1'b1, 1'b0, 2'd0, 3'd4, 32'd0, rd, cyc);
    chk("R10 delayed ack latency", cyc, 5);
    chk("R10 delayed ack data", rd, PAT);
    ack_wait = 0;

    finish_up();
  end

endmodule